// File: doc/BRIEF.md
# Dual-Rate Machine Cycle Generator

This block turns a free-running oscillator clock into the timing enables a small processor core and its peripherals use. A machine cycle is split into six states, and each state has a first and a second phase. In standard mode the oscillator is halved before it drives the state sequence, so each state spans two oscillator periods and a machine cycle spans twelve. In double-speed mode the halving is bypassed: each state lasts one oscillator period, both phase enables fire together, and a machine cycle spans six. Nothing in the block gates a clock. Every output is an enable or a strobe, and all of them are decoded from registers clocked by the oscillator.

The block also produces the address-latch strobe. This strobe pulses twice per machine cycle, so it runs at one sixth of the oscillator rate in standard mode and at one third in double-speed mode. A one-cycle data-access request removes the next pulse that has not yet begun. A per-machine-cycle tick is provided for timers, so peripheral time references run twice as fast in double-speed mode. The speed-select input may change at any time. It is adopted only on the oscillator edge that closes a standard-mode state, which is where the internal half-rate clock rises. As a result, no state and no phase is ever cut short.

Top module: `mcycle_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the block is in standard mode at state S1 with `state_o` = 6'b000001 (bit k set means state S(k+1)), `ph1_en_o` = 1, `ph2_en_o` = 0, `mcycle_o` = 1, `ale_o` = 0 and `periph_tick_o` = 0, whatever `x2_sel_i` holds.
- R2: In standard mode every state lasts exactly two oscillator cycles. `ph1_en_o` alone is high in the first cycle and `ph2_en_o` alone in the second, so a machine cycle is 12 oscillator cycles.
- R3: In double-speed mode every state lasts one oscillator cycle with `ph1_en_o` and `ph2_en_o` both high, so a machine cycle is 6 oscillator cycles.
- R4: `x2_sel_i` is sampled only at the clock edge that ends a standard-mode state (the second of each pair of oscillator cycles counted from reset). A value that is present only on other edges has no effect, and the state in progress when the mode changes keeps its full length.
- R5: `state_o` is always one-hot and steps S1, S2, S3, S4, S5, S6, S1 in that order.
- R6: `ale_o` is high during the second phase of S1 and S4 and during the first phase of S2 and S5. This gives two pulses per machine cycle, each lasting two oscillator cycles in either mode.
- R7: A high `xdata_i` in any cycle suppresses, as a whole, the first address-latch pulse that starts in a later cycle. Holding it high suppresses every pulse. One pulse is removed per request.
- R8: `mcycle_o` is high exactly in the first-phase cycle of S1, once per machine cycle.
- R9: `periph_tick_o` is high exactly in the second-phase cycle of S6, once per machine cycle. It therefore occurs twice as often in double-speed mode, and the next cycle always carries `mcycle_o`.
- R10: `state_o` changes only on an edge that ends a cycle in which `ph2_en_o` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| x2_sel_i | input | 1 | Speed select: 1 requests double-speed mode |
| xdata_i | input | 1 | Data-access request; suppresses the next address-latch pulse |
| state_o | output | 6 | One-hot state index, bit 0 = S1 |
| ph1_en_o | output | 1 | First-phase enable of the current state |
| ph2_en_o | output | 1 | Second-phase enable of the current state |
| mcycle_o | output | 1 | Machine-cycle start strobe |
| ale_o | output | 1 | Address-latch strobe |
| periph_tick_o | output | 1 | Once-per-machine-cycle timer enable |

## Verification
Five properties are checked on every cycle:
- the state vector stays one-hot;
- the state advances only after a second-phase cycle;
- the adopted speed changes only at a half-rate boundary;
- no address-latch pulse lasts longer than two cycles;
- every peripheral tick is followed by a machine-cycle start.

Other behaviours depend on what the inputs did and in which cycle, so only the bench's scenarios can show them:
- the exact cycle-by-cycle placement of the phases and strobes across both speed switches;
- the deferral of a mode request that arrives off a boundary;
- which particular address-latch pulse a data-access request removes;
- the doubled tick rate.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    // Prescaler state: half-rate toggle and adopted speed mode.
    typedef struct packed {
        logic half;
        logic x2;
    } presc_t;

    // Address-latch suppression state.
    typedef struct packed {
        logic pend;   // a request is waiting for the next pulse
        logic supp;   // the pulse in progress is being blanked
    } skip_t;

    localparam int unsigned MCG_STATES = 6;
    localparam int unsigned MCG_PULSES = 2;

endpackage

// File: rtl/mcg_prescaler.sv
module mcg_prescaler
    import mcg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic x2_req_i,
    output logic ph1_o,
    output logic ph2_o
);

    presc_t q, d;

    always_comb begin
        d      = q;
        d.half = ~q.half;
        // The half-rate clock rises on the edge closing a standard state:
        // only there is a new speed adopted.
        if (q.half) begin
            d.x2 = x2_req_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // In double-speed mode both phases share one cycle.
    assign ph1_o = q.x2 | ~q.half;
    assign ph2_o = q.x2 |  q.half;

    assert_mode_on_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.x2 != $past(q.x2)) |-> $past(q.half));

endmodule

// File: rtl/mcg_sequencer.sv
module mcg_sequencer #(
    parameter int unsigned NUM_STATES = 6
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ph1_i,
    input  logic                  ph2_i,
    output logic [NUM_STATES-1:0] state_o,
    output logic                  mcycle_o,
    output logic                  tick_o
);

    localparam int unsigned LAST = NUM_STATES - 1;

    typedef struct packed {
        logic [NUM_STATES-1:0] st;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (ph2_i) begin
            d.st = {q.st[LAST-1:0], q.st[LAST]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st <= NUM_STATES'(1);
        end else begin
            q <= d;
        end
    end

    assign state_o  = q.st;
    assign mcycle_o = q.st[0]    & ph1_i;
    assign tick_o   = q.st[LAST] & ph2_i;

    assert_state_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(q.st) == 1);

    assert_advance_after_ph2_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(q.st) |-> $past(ph2_i));

endmodule

// File: rtl/mcg_ale.sv
module mcg_ale
    import mcg_pkg::*;
#(
    parameter int unsigned NUM_STATES = 6,
    parameter int unsigned NUM_PULSES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ph1_i,
    input  logic                  ph2_i,
    input  logic [NUM_STATES-1:0] state_i,
    input  logic                  xdata_i,
    output logic                  ale_o
);

    localparam int unsigned SPACING = NUM_STATES / NUM_PULSES;

    logic [NUM_PULSES-1:0] head_v;
    logic [NUM_PULSES-1:0] tail_v;
    logic                  start;
    logic                  window;

    // Each pulse covers the second phase of its anchor state and the
    // first phase of the following state.
    for (genvar p = 0; p < NUM_PULSES; p++) begin : g_pulse
        assign head_v[p] = ph2_i & state_i[p*SPACING];
        assign tail_v[p] = ph1_i & state_i[p*SPACING + 1];
    end

    assign start  = |head_v;
    assign window = start | (|tail_v);

    skip_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.supp = q.pend;
            d.pend = xdata_i;
        end else begin
            d.pend = q.pend | xdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ale_o = window & ~(start ? q.pend : q.supp);

    assert_ale_max_two_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ale_o && $past(ale_o)) |=> !ale_o);

endmodule

// File: rtl/mcycle_gen.sv
module mcycle_gen
    import mcg_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  x2_sel_i,
    input  logic                  xdata_i,
    output logic [MCG_STATES-1:0] state_o,
    output logic                  ph1_en_o,
    output logic                  ph2_en_o,
    output logic                  mcycle_o,
    output logic                  ale_o,
    output logic                  periph_tick_o
);

    logic                  ph1;
    logic                  ph2;
    logic [MCG_STATES-1:0] st;

    mcg_prescaler u_presc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .x2_req_i (x2_sel_i),
        .ph1_o    (ph1),
        .ph2_o    (ph2)
    );

    mcg_sequencer #(.NUM_STATES(MCG_STATES)) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ph1_i    (ph1),
        .ph2_i    (ph2),
        .state_o  (st),
        .mcycle_o (mcycle_o),
        .tick_o   (periph_tick_o)
    );

    mcg_ale #(.NUM_STATES(MCG_STATES), .NUM_PULSES(MCG_PULSES)) u_ale (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ph1_i   (ph1),
        .ph2_i   (ph2),
        .state_i (st),
        .xdata_i (xdata_i),
        .ale_o   (ale_o)
    );

    assign state_o  = st;
    assign ph1_en_o = ph1;
    assign ph2_en_o = ph2;

    assert_tick_then_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        periph_tick_o |=> mcycle_o);

endmodule

// File: tb/sim_mcycle_gen.sv
module sim_mcycle_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       x2_sel = 1'b0;
    logic       xdata = 1'b0;
    logic [5:0] state;
    logic       ph1, ph2, mc, ale, tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mcycle_gen u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .x2_sel_i      (x2_sel),
        .xdata_i       (xdata),
        .state_o       (state),
        .ph1_en_o      (ph1),
        .ph2_en_o      (ph2),
        .mcycle_o      (mc),
        .ale_o         (ale),
        .periph_tick_o (tick)
    );

    // {x2_sel, xdata, state[5:0], ph1, ph2, ale, mcycle, tick}
    localparam int NV = 35;
    localparam logic [12:0] VEC [NV] = '{
        13'b0_0_000001_1_0_0_1_0, // c0  reset exit, S1 (R1)
        13'b0_0_000001_0_1_1_0_0,
        13'b0_1_000010_1_0_1_0_0, // xdata request mid-pulse (R7)
        13'b0_0_000010_0_1_0_0_0,
        13'b0_0_000100_1_0_0_0_0,
        13'b0_0_000100_0_1_0_0_0,
        13'b0_0_001000_1_0_0_0_0,
        13'b0_0_001000_0_1_0_0_0, // S4 pulse suppressed (R7)
        13'b0_0_010000_1_0_0_0_0,
        13'b0_0_010000_0_1_0_0_0,
        13'b0_0_100000_1_0_0_0_0,
        13'b0_0_100000_0_1_0_0_1,
        13'b1_0_000001_1_0_0_1_0, // c12 request double speed off boundary (R4)
        13'b1_0_000001_0_1_1_0_0, // S1 keeps its full length
        13'b1_0_000010_1_1_1_0_0, // double speed from here (R3)
        13'b1_0_000100_1_1_0_0_0,
        13'b1_0_001000_1_1_1_0_0,
        13'b1_0_010000_1_1_1_0_0,
        13'b1_0_100000_1_1_0_0_1,
        13'b1_0_000001_1_1_1_1_0,
        13'b1_0_000010_1_1_1_0_0,
        13'b1_0_000100_1_1_0_0_0,
        13'b1_1_001000_1_1_1_0_0, // request in a start cycle: this pulse stays
        13'b1_0_010000_1_1_1_0_0,
        13'b1_0_100000_1_1_0_0_1,
        13'b1_0_000001_1_1_0_1_0, // S1 pulse suppressed
        13'b1_0_000010_1_1_0_0_0,
        13'b0_0_000100_1_1_0_0_0, // back to standard, taken at this edge (R4)
        13'b0_0_001000_1_0_0_0_0,
        13'b0_0_001000_0_1_1_0_0,
        13'b0_0_010000_1_0_1_0_0,
        13'b0_0_010000_0_1_0_0_0,
        13'b0_0_100000_1_0_0_0_0,
        13'b0_0_100000_0_1_0_0_1,
        13'b0_0_000001_1_0_0_1_0
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_outs(input string req, input logic [5:0] s, input logic p1,
                            input logic p2, input logic a, input logic m, input logic t);
        chk(state == s, req, state, s);
        chk(ph1 == p1 && ph2 == p2, req, {ph1, ph2}, {p1, p2});
        chk(ale == a, req, ale, a);
        chk(mc == m && tick == t, req, {mc, tick}, {m, t});
    endtask

    // Counts over n cycles; also checks R10 (state moves only after ph2).
    task automatic measure(input int n, output int nmc, output int ntk, output int nrise);
        logic pa, pp2;
        logic [5:0] ps;
        nmc = 0; ntk = 0; nrise = 0;
        pa = ale; pp2 = ph2; ps = state;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (state != ps) chk(pp2, "R10", pp2, 1);
            if (mc) nmc++;
            if (tick) ntk++;
            if (ale && !pa) nrise++;
            pa = ale; pp2 = ph2; ps = state;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int a, b, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Table walk from reset release.
        for (int i = 0; i < NV; i++) begin
            if (i > 0) @(negedge clk);
            chk(state == VEC[i][10:5], "R5", state, VEC[i][10:5]);
            chk(ph1 == VEC[i][4] && ph2 == VEC[i][3], "R2/R3/R4", {ph1, ph2}, VEC[i][4:3]);
            chk(ale == VEC[i][2], "R6/R7", ale, VEC[i][2]);
            chk(mc == VEC[i][1], "R8", mc, VEC[i][1]);
            chk(tick == VEC[i][0], "R9", tick, VEC[i][0]);
            x2_sel = VEC[i][12];
            xdata  = VEC[i][11];
        end

        // Standard-mode rates: 12 cycles per machine cycle (R2, R6, R8, R9).
        measure(120, a, b, c);
        chk(a == 10, "R8", a, 10);
        chk(b == 10, "R9", b, 10);
        chk(c == 20, "R6", c, 20);

        // Double-speed rates: 6 cycles per machine cycle (R3, R9).
        x2_sel = 1'b1;
        repeat (4) @(negedge clk);
        measure(60, a, b, c);
        chk(a == 10, "R3", a, 10);
        chk(b == 10, "R9", b, 10);
        chk(c == 20, "R6", c, 20);

        // Held data-access request blanks every pulse (R7).
        xdata = 1'b1;
        repeat (3) @(negedge clk);
        measure(30, a, b, c);
        chk(c == 0, "R7", c, 0);
        xdata = 1'b0;
        repeat (6) @(negedge clk);
        measure(30, a, b, c);
        chk(c == 10, "R7", c, 10);

        // Reset while in double speed with the request still high (R1).
        rst_n = 1'b0;
        #1;
        chk_outs("R1", 6'b000001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk_outs("R1", 6'b000001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        chk_outs("R1", 6'b000001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);   // c0
        @(negedge clk);
        chk_outs("R4", 6'b000001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);   // c1 standard
        @(negedge clk);
        chk_outs("R4", 6'b000010, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);   // c2 double
        x2_sel = 1'b0;                                              // not taken here
        @(negedge clk);
        chk_outs("R4", 6'b000100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // c3 still double
        @(negedge clk);
        chk_outs("R2", 6'b001000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);   // c4 standard
        x2_sel = 1'b1;                                              // one-cycle glitch
        @(negedge clk);
        x2_sel = 1'b0;
        chk_outs("R4", 6'b001000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);   // c5 ignored
        @(negedge clk);
        chk_outs("R4", 6'b010000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);   // c6 still standard

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule